// File: doc/BRIEF.md
# Splittable Three-Input Logic ALU

This block is the logic and add/subtract portion of a 32-bit data unit in an image-processing datapath. Each accepted operation takes three source words, A, B and C. It produces one registered result and a set of per-lane carry flags, one cycle later. The Boolean mode applies any one of the 256 functions of three inputs to every bit position. An 8-bit function code selects the function.

The adder can work as one 32-bit word or split into two independent 16-bit lanes or four independent 8-bit lanes. This lets pixel data be processed several samples at a time. Two mask sources are built in:
- A generator that yields a run of low-order ones whose length is set by A.
- An expander that turns the low bits of a mask-flag input into whole byte, halfword or word masks.

Status flags supplied from outside control two things. They can pick the B operand from two candidates, and they can suppress the write of the result. When the write is suppressed, the previous destination value is kept.

Top module: `tri_lane_alu`

## Requirements
- R1: With op_i=0 (logic), result bit i equals func_i[{A[i],B[i],C[i]}], with A as the most significant index bit. For example, code 0xF0 returns A, 0xCC returns B, 0xAA returns C, 0x96 returns A^B^C and 0xE8 returns the bitwise majority.
- R2: With size_i=0 (word), op_i=1 gives A+B and op_i=2 gives A-B over 32 bits. The carry out appears on lane_cout_o[0]: for subtract it is 1 when no borrow occurs. The other carry bits are 0.
- R3: With size_i=1 (halfword), bits 15:0 and bits 31:16 add or subtract independently, and no carry crosses bit 16. The lane carries appear on lane_cout_o[1:0], and bits 3:2 are 0.
- R4: With size_i=2 or 3 (byte), the four bytes add or subtract independently. The carry of byte k appears on lane_cout_o[k].
- R5: With op_i=3 (mask generate), the result has its n low bits set, where n=src_a_i[5:0]. n=0 gives 0, and any n of 32 or more gives all ones.
- R6: With op_i=4 (expand), the result is built from mf_i:
  - byte size: bit k fills byte k;
  - halfword size: bits 1:0 fill the two halves;
  - word size: bit 0 fills the whole word.
  For example, mf_i=0x3 with byte size gives 0x0000FFFF.
- R7: The writeback condition wr_cond_i is encoded as follows:
  - 0: always write;
  - 1: write only when flg_lt_i=1;
  - 2: write only when flg_lt_i=0;
  - 3: never write.
  When no write occurs, res_o and lane_cout_o keep their values and done_o stays 0.
- R8: When sel_neg_i=1, the B operand is src_b_i if flg_neg_i=1 and src_alt_i otherwise. When sel_neg_i=0, B is always src_b_i.
- R9: After a synchronous reset, res_o, lane_cout_o and done_o are 0.
- R10: An operation accepted at a rising edge with in_valid_i=1 updates the outputs at that same edge, and done_o is high for exactly that one cycle. Operations other than add and subtract write lane_cout_o as 0. op_i values 5 to 7 give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | 0 logic, 1 add, 2 subtract, 3 mask generate, 4 expand |
| func_i | input | 8 | Three-input Boolean function code |
| size_i | input | 2 | 0 word, 1 halfword, 2/3 byte |
| wr_cond_i | input | 2 | Writeback condition code |
| sel_neg_i | input | 1 | Enable flag-controlled B selection |
| flg_neg_i | input | 1 | Negative status flag |
| flg_lt_i | input | 1 | Less-than status flag |
| src_a_i | input | 32 | Operand A (also mask length) |
| src_b_i | input | 32 | Operand B, first alternative |
| src_alt_i | input | 32 | Operand B, second alternative |
| src_c_i | input | 32 | Operand C |
| mf_i | input | 4 | Mask-flag bits for the expander |
| res_o | output | 32 | Registered result |
| lane_cout_o | output | 4 | Registered per-lane carry flags |
| done_o | output | 1 | Pulses when a result was written |

## Verification
The assertions assume that every control input is steady and defined whenever in_valid_i is high. They also assume that op_i, size_i and wr_cond_i only take values from the encodings listed above. Outside those conditions the checks on carry and mask shape would have no meaning. The stimulus changes inputs only on the falling clock edge. It holds in_valid_i high for a single cycle per operation and returns it low before the next one, so each check relates to exactly one accepted operation. The mask-length operand covers 0, values inside the word and values of 32 and above, so the saturation path is reached without undefined input bits.

// File: rtl/tla_pkg.sv
package tla_pkg;
  localparam logic [2:0] OP_BOOL = 3'd0;
  localparam logic [2:0] OP_ADD  = 3'd1;
  localparam logic [2:0] OP_SUB  = 3'd2;
  localparam logic [2:0] OP_MGEN = 3'd3;
  localparam logic [2:0] OP_EXP  = 3'd4;

  localparam logic [1:0] SZ_WORD = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  localparam logic [1:0] WC_ALWAYS = 2'd0;
  localparam logic [1:0] WC_LT     = 2'd1;
  localparam logic [1:0] WC_NLT    = 2'd2;
endpackage

// File: rtl/tla_bool3.sv
module tla_bool3 #(
  parameter int DATA_W = 32
) (
  input  logic [7:0]        func,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] c,
  output logic [DATA_W-1:0] y
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign y[i] = func[{a[i], b[i], c[i]}];
  end
endmodule

// File: rtl/tla_lane_adder.sv
module tla_lane_adder
  import tla_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SLICE_W = 8,
  localparam int NS     = DATA_W / SLICE_W
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] sum,
  output logic [NS-1:0]     cout
);
  logic [NS:0]   chain;
  logic [NS-1:0] start;
  assign chain[0] = sub;

  for (genvar k = 0; k < NS; k++) begin : g_slice
    logic [SLICE_W-1:0] bx;
    logic               cin;
    assign start[k] = (size == SZ_WORD) ? (k == 0) :
                      (size == SZ_HALF) ? (k % 2 == 0) : 1'b1;
    assign bx  = b[k*SLICE_W +: SLICE_W] ^ {SLICE_W{sub}};
    assign cin = start[k] ? sub : chain[k];
    assign {chain[k+1], sum[k*SLICE_W +: SLICE_W]} =
      {1'b0, a[k*SLICE_W +: SLICE_W]} + {1'b0, bx} + {{SLICE_W{1'b0}}, cin};
  end

  always_comb begin
    cout = '0;
    for (int k = 0; k < NS; k++) begin
      if (size == SZ_WORD) begin
        if (k == NS - 1) cout[0] = chain[k+1];
      end else if (size == SZ_HALF) begin
        if (k % 2 == 1) cout[k/2] = chain[k+1];
      end else begin
        cout[k] = chain[k+1];
      end
    end
  end
endmodule

// File: rtl/tla_mask_unit.sv
module tla_mask_unit
  import tla_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SLICE_W = 8,
  localparam int NS     = DATA_W / SLICE_W,
  localparam int ARG_W  = $clog2(DATA_W) + 1
) (
  input  logic [ARG_W-1:0]  arg,
  input  logic [NS-1:0]     mf,
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] gen_mask,
  output logic [DATA_W-1:0] exp_mask
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_gen
    assign gen_mask[i] = (int'(arg) > i);
  end

  for (genvar k = 0; k < NS; k++) begin : g_exp
    logic pick;
    assign pick = (size == SZ_WORD) ? mf[0] :
                  (size == SZ_HALF) ? mf[k/2] : mf[k];
    assign exp_mask[k*SLICE_W +: SLICE_W] = {SLICE_W{pick}};
  end
endmodule

// File: rtl/tri_lane_alu.sv
module tri_lane_alu
  import tla_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SLICE_W = 8,
  localparam int NS     = DATA_W / SLICE_W,
  localparam int ARG_W  = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid_i,
  input  logic [2:0]        op_i,
  input  logic [7:0]        func_i,
  input  logic [1:0]        size_i,
  input  logic [1:0]        wr_cond_i,
  input  logic              sel_neg_i,
  input  logic              flg_neg_i,
  input  logic              flg_lt_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [DATA_W-1:0] src_alt_i,
  input  logic [DATA_W-1:0] src_c_i,
  input  logic [NS-1:0]     mf_i,
  output logic [DATA_W-1:0] res_o,
  output logic [NS-1:0]     lane_cout_o,
  output logic              done_o
);
  logic [DATA_W-1:0] b_eff, bool_y, sum_y, gen_y, exp_y, nxt_res;
  logic [NS-1:0]     sum_c, nxt_cout;
  logic              cond_ok, wr_en;

  assign b_eff = (sel_neg_i && !flg_neg_i) ? src_alt_i : src_b_i;

  tla_bool3 #(.DATA_W(DATA_W)) u_bool (
    .func(func_i), .a(src_a_i), .b(b_eff), .c(src_c_i), .y(bool_y)
  );

  tla_lane_adder #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_add (
    .a(src_a_i), .b(b_eff), .sub(op_i == OP_SUB), .size(size_i),
    .sum(sum_y), .cout(sum_c)
  );

  tla_mask_unit #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_mask (
    .arg(src_a_i[ARG_W-1:0]), .mf(mf_i), .size(size_i),
    .gen_mask(gen_y), .exp_mask(exp_y)
  );

  always_comb begin
    unique case (wr_cond_i)
      WC_ALWAYS: cond_ok = 1'b1;
      WC_LT:     cond_ok = flg_lt_i;
      WC_NLT:    cond_ok = !flg_lt_i;
      default:   cond_ok = 1'b0;
    endcase
  end
  assign wr_en = in_valid_i && cond_ok;

  always_comb begin
    nxt_cout = '0;
    case (op_i)
      OP_BOOL: nxt_res = bool_y;
      OP_ADD, OP_SUB: begin
        nxt_res  = sum_y;
        nxt_cout = sum_c;
      end
      OP_MGEN: nxt_res = gen_y;
      OP_EXP:  nxt_res = exp_y;
      default: nxt_res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o       <= '0;
      lane_cout_o <= '0;
      done_o      <= 1'b0;
    end else begin
      done_o <= wr_en;
      if (wr_en) begin
        res_o       <= nxt_res;
        lane_cout_o <= nxt_cout;
      end
    end
  end

  // R1: code 0xF0 passes A straight through
  a_r1_pass_a: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op_i == OP_BOOL && func_i == 8'hF0) |=> res_o == $past(src_a_i));

  // R3: halfword split leaves the upper carry flags clear
  a_r3_half_cout: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (op_i == OP_ADD || op_i == OP_SUB) && size_i == SZ_HALF)
      |=> (lane_cout_o >> (NS/2)) == '0);

  // R5: generated mask has min(n, DATA_W) ones
  a_r5_mask_count: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op_i == OP_MGEN) |=>
      $countones(res_o) == ((int'($past(src_a_i[ARG_W-1:0])) > DATA_W) ?
                            DATA_W : int'($past(src_a_i[ARG_W-1:0]))));

  // R6: byte expansion yields uniform slices
  for (genvar k = 0; k < NS; k++) begin : g_chk
    a_r6_uniform_slice: assert property (@(posedge clk) disable iff (rst)
      (wr_en && op_i == OP_EXP) |=>
        (res_o[k*SLICE_W +: SLICE_W] == '0 || res_o[k*SLICE_W +: SLICE_W] == '1));
  end

  // R7: a suppressed write leaves the outputs untouched
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && !wr_en) |=> ($stable(res_o) && $stable(lane_cout_o) && !done_o));
endmodule

// File: tb/tri_lane_alu_tb.sv
module tri_lane_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [7:0]  func_i = '0;
  logic [1:0]  size_i = '0;
  logic [1:0]  wr_cond_i = '0;
  logic        sel_neg_i = 1'b0;
  logic        flg_neg_i = 1'b0;
  logic        flg_lt_i = 1'b0;
  logic [31:0] src_a_i = '0, src_b_i = '0, src_alt_i = '0, src_c_i = '0;
  logic [3:0]  mf_i = '0;
  logic [31:0] res_o;
  logic [3:0]  lane_cout_o;
  logic        done_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tri_lane_alu dut_i (
    .clk(clk), .rst(rst), .in_valid_i(in_valid_i), .op_i(op_i), .func_i(func_i),
    .size_i(size_i), .wr_cond_i(wr_cond_i), .sel_neg_i(sel_neg_i),
    .flg_neg_i(flg_neg_i), .flg_lt_i(flg_lt_i), .src_a_i(src_a_i),
    .src_b_i(src_b_i), .src_alt_i(src_alt_i), .src_c_i(src_c_i), .mf_i(mf_i),
    .res_o(res_o), .lane_cout_o(lane_cout_o), .done_o(done_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] op, logic [7:0] fn, logic [1:0] sz, logic [1:0] wc,
                       logic [31:0] a, logic [31:0] b, logic [31:0] c, logic [3:0] mf);
    @(negedge clk);
    in_valid_i = 1'b1; op_i = op; func_i = fn; size_i = sz; wr_cond_i = wc;
    src_a_i = a; src_b_i = b; src_c_i = c; mf_i = mf;
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 res", res_o, 32'h0);
    chk("R9 cout", {28'h0, lane_cout_o}, 32'h0);
    chk("R9 done", {31'h0, done_o}, 32'h0);
    rst = 1'b0;
  endtask

  task automatic t_bool;
    logic [31:0] a = 32'hF0F0_3C5A, b = 32'hCCCC_A50F, c = 32'hAAAA_0FF0;
    issue(3'd0, 8'hF0, 2'd0, 2'd0, a, b, c, 4'h0);
    chk("R1 F0", res_o, a);
    chk("R10 done", {31'h0, done_o}, 32'h1);
    chk("R10 cout zero", {28'h0, lane_cout_o}, 32'h0);
    issue(3'd0, 8'hCC, 2'd0, 2'd0, a, b, c, 4'h0);
    chk("R1 CC", res_o, b);
    issue(3'd0, 8'hAA, 2'd0, 2'd0, a, b, c, 4'h0);
    chk("R1 AA", res_o, c);
    issue(3'd0, 8'h96, 2'd0, 2'd0, a, b, c, 4'h0);
    chk("R1 96", res_o, a ^ b ^ c);
    issue(3'd0, 8'hE8, 2'd0, 2'd0, a, b, c, 4'h0);
    chk("R1 E8", res_o, (a & b) | (a & c) | (b & c));
    issue(3'd0, 8'h80, 2'd0, 2'd0, a, b, c, 4'h0);
    chk("R1 80", res_o, a & b & c);
    issue(3'd6, 8'hFF, 2'd0, 2'd0, a, b, c, 4'h0);
    chk("R10 reserved op", res_o, 32'h0);
  endtask

  task automatic t_word;
    issue(3'd1, 8'h0, 2'd0, 2'd0, 32'hFFFF_FFFF, 32'h1, 32'h0, 4'h0);
    chk("R2 add wrap", res_o, 32'h0);
    chk("R2 add cout", {28'h0, lane_cout_o}, 32'h1);
    issue(3'd2, 8'h0, 2'd0, 2'd0, 32'h5, 32'h7, 32'h0, 4'h0);
    chk("R2 sub borrow", res_o, 32'hFFFF_FFFE);
    chk("R2 sub cout", {28'h0, lane_cout_o}, 32'h0);
    issue(3'd2, 8'h0, 2'd0, 2'd0, 32'h7, 32'h5, 32'h0, 4'h0);
    chk("R2 sub ok", res_o, 32'h2);
    chk("R2 sub cout1", {28'h0, lane_cout_o}, 32'h1);
  endtask

  task automatic t_half;
    issue(3'd1, 8'h0, 2'd1, 2'd0, 32'h0001_FFFF, 32'h0000_0001, 32'h0, 4'h0);
    chk("R3 add", res_o, 32'h0001_0000);
    chk("R3 cout", {28'h0, lane_cout_o}, 32'h1);
    issue(3'd2, 8'h0, 2'd1, 2'd0, 32'h0000_0003, 32'h0001_0001, 32'h0, 4'h0);
    chk("R3 sub", res_o, 32'hFFFF_0002);
    chk("R3 sub cout", {28'h0, lane_cout_o}, 32'h1);
  endtask

  task automatic t_byte;
    issue(3'd1, 8'h0, 2'd2, 2'd0, 32'h80FF_7F01, 32'h8001_0101, 32'h0, 4'h0);
    chk("R4 add", res_o, 32'h0000_8002);
    chk("R4 cout", {28'h0, lane_cout_o}, 32'hC);
    issue(3'd2, 8'h0, 2'd3, 2'd0, 32'h0005_0300, 32'h0102_0300, 32'h0, 4'h0);
    chk("R4 sub", res_o, 32'hFF03_0000);
    chk("R4 sub cout", {28'h0, lane_cout_o}, 32'h7);
  endtask

  task automatic t_mgen;
    issue(3'd3, 8'h0, 2'd0, 2'd0, 32'd7, 32'h0, 32'h0, 4'h0);
    chk("R5 n7", res_o, 32'h0000_007F);
    issue(3'd3, 8'h0, 2'd0, 2'd0, 32'd0, 32'h0, 32'h0, 4'h0);
    chk("R5 n0", res_o, 32'h0);
    issue(3'd3, 8'h0, 2'd0, 2'd0, 32'd31, 32'h0, 32'h0, 4'h0);
    chk("R5 n31", res_o, 32'h7FFF_FFFF);
    issue(3'd3, 8'h0, 2'd0, 2'd0, 32'd32, 32'h0, 32'h0, 4'h0);
    chk("R5 n32", res_o, 32'hFFFF_FFFF);
    issue(3'd3, 8'h0, 2'd0, 2'd0, 32'd63, 32'h0, 32'h0, 4'h0);
    chk("R5 n63", res_o, 32'hFFFF_FFFF);
  endtask

  task automatic t_expand;
    issue(3'd4, 8'h0, 2'd2, 2'd0, 32'h0, 32'h0, 32'h0, 4'h3);
    chk("R6 byte 3", res_o, 32'h0000_FFFF);
    issue(3'd4, 8'h0, 2'd2, 2'd0, 32'h0, 32'h0, 32'h0, 4'hA);
    chk("R6 byte A", res_o, 32'hFF00_FF00);
    issue(3'd4, 8'h0, 2'd1, 2'd0, 32'h0, 32'h0, 32'h0, 4'h2);
    chk("R6 half 2", res_o, 32'hFFFF_0000);
    issue(3'd4, 8'h0, 2'd0, 2'd0, 32'h0, 32'h0, 32'h0, 4'h1);
    chk("R6 word 1", res_o, 32'hFFFF_FFFF);
    issue(3'd4, 8'h0, 2'd0, 2'd0, 32'h0, 32'h0, 32'h0, 4'hE);
    chk("R6 word E", res_o, 32'h0);
  endtask

  task automatic t_cond;
    issue(3'd1, 8'h0, 2'd0, 2'd0, 32'h1111_1110, 32'h1, 32'h0, 4'h0);
    chk("R7 base", res_o, 32'h1111_1111);
    flg_lt_i = 1'b0;
    issue(3'd1, 8'h0, 2'd0, 2'd1, 32'hFFFF_FFFF, 32'h1, 32'h0, 4'h0);
    chk("R7 lt false holds", res_o, 32'h1111_1111);
    chk("R7 lt false cout", {28'h0, lane_cout_o}, 32'h0);
    chk("R7 lt false done", {31'h0, done_o}, 32'h0);
    flg_lt_i = 1'b1;
    issue(3'd1, 8'h0, 2'd0, 2'd1, 32'h2, 32'h3, 32'h0, 4'h0);
    chk("R7 lt true", res_o, 32'h5);
    issue(3'd1, 8'h0, 2'd0, 2'd3, 32'h9, 32'h9, 32'h0, 4'h0);
    chk("R7 never", res_o, 32'h5);
    chk("R7 never done", {31'h0, done_o}, 32'h0);
    issue(3'd1, 8'h0, 2'd0, 2'd2, 32'h9, 32'h9, 32'h0, 4'h0);
    chk("R7 nlt with lt", res_o, 32'h5);
    flg_lt_i = 1'b0;
    issue(3'd1, 8'h0, 2'd0, 2'd2, 32'h9, 32'h9, 32'h0, 4'h0);
    chk("R7 nlt", res_o, 32'h12);
    @(negedge clk);
    chk("R10 done one cycle", {31'h0, done_o}, 32'h0);
  endtask

  task automatic t_select;
    src_alt_i = 32'h0000_0100;
    sel_neg_i = 1'b1; flg_neg_i = 1'b1;
    issue(3'd1, 8'h0, 2'd0, 2'd0, 32'h10, 32'h20, 32'h0, 4'h0);
    chk("R8 neg1", res_o, 32'h30);
    flg_neg_i = 1'b0;
    issue(3'd1, 8'h0, 2'd0, 2'd0, 32'h10, 32'h20, 32'h0, 4'h0);
    chk("R8 neg0", res_o, 32'h110);
    sel_neg_i = 1'b0;
    issue(3'd1, 8'h0, 2'd0, 2'd0, 32'h10, 32'h20, 32'h0, 4'h0);
    chk("R8 off", res_o, 32'h30);
  endtask

  initial begin
    t_reset();
    t_bool();
    t_word();
    t_half();
    t_byte();
    t_mgen();
    t_expand();
    t_cond();
    t_select();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule